// File: doc/BRIEF.md
# Queued-Select SPI Master

This block is a full-duplex SPI master. The host loads words into a small transmit queue. Each word is shifted out on the serial data output, most significant bit first. At the same time the same number of bits is captured from the serial data input, and each finished incoming word is placed in a receive queue for the host to collect.

The select line is handled by the queue, not by software. A word that is already waiting when the current word ends is shifted on the next bit period. Select stays active and there is no idle slot between the two words. Select is released only after a word finishes and the transmit queue is empty. A long transaction, such as a 32-bit conversion result read as two 16-bit words, therefore runs as one uninterrupted select window.

The serial clock uses mode 0: it idles low, output data changes on the falling edge and input data is sampled on the rising edge. One half period lasts a programmable number of system clocks.

Top module: `spi_qcs_master`

## Requirements
- R1: After reset, select is high, the serial clock is low, busy is low, the transmit queue reports empty and not-full, no received word is available and the overflow flag is clear.
- R2: Each word is driven on `mosi` most significant bit first, and the bits sampled on `miso` at the rising edges of the same word form the received word, also most significant bit first.
- R3: The serial clock idles low and `mosi` never changes at a rising edge of the serial clock.
- R4: While select is active, each high and low phase of the serial clock lasts `half_div` system clocks. A value of 0 acts as 1.
- R5: A word that is queued before the current word's last falling edge follows with no extra gap: the spacing between edges stays one half period, and select stays low across both words.
- R6: A single queued word produces exactly one select window with exactly WORD_W rising edges. Select rises only after a word ends while the transmit queue is empty.
- R7: Between the fall of select and the first rising edge there is one half period, and between the last falling edge and the rise of select there is also one half period.
- R8: The transmit queue holds 4 words. `tx_not_full` goes low when it is full, and a push while it is full is refused: that word is never sent.
- R9: The receive queue holds 4 words. A word that completes while the receive queue is full is dropped and sets `rx_overflow`. The flag stays set until the host pops a word, which clears it.
- R10: `busy` is high from the fall of select until its rise, and low otherwise.
- R11: With nothing queued, the serial clock does not toggle and select stays high.
- R12: With WORD_W set to 8, the same behaviour holds: 8 rising edges per word, and back-to-back words stay in one window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| half_div | input | DIV_W | System clocks per serial clock half period |
| tx_data | input | WORD_W | Word to queue for transmission |
| tx_push | input | 1 | Queue `tx_data` (refused when full) |
| tx_not_full | output | 1 | Transmit queue can take a word |
| tx_empty | output | 1 | Transmit queue holds no word |
| rx_data | output | WORD_W | Oldest received word |
| rx_pop | input | 1 | Remove the oldest received word and clear overflow |
| rx_valid | output | 1 | A received word is available |
| rx_overflow | output | 1 | Sticky flag: a received word was dropped |
| sclk | output | 1 | Serial clock, mode 0 |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Active-low slave select |
| busy | output | 1 | Select window in progress |

## Verification
The bench builds two instances: one with 16-bit words, which is the main configuration, and one with 8-bit words. Both use 4-entry queues, so a burst of six pushes fills the transmit queue and five completed words overrun the receive queue. A slave model answers each window with an incrementing reply, so the ordering of the returned words and the dropped word can be seen directly. Running with half-period divisors of 1, 2 and 3 makes the setup time, the hold time and the edge spacing measurable in whole system clocks.

// File: rtl/spi_qcs_pkg.sv
`timescale 1ns/1ps
package spi_qcs_pkg;
  // Engine states: waiting for a word, shifting, holding select before release.
  typedef enum logic [1:0] {
    ENG_IDLE  = 2'd0,
    ENG_SHIFT = 2'd1,
    ENG_HOLD  = 2'd2
  } eng_state_t;
endpackage

// File: rtl/spi_qcs_fifo.sv
`timescale 1ns/1ps
module spi_qcs_fifo #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  input  logic             pop,
  output logic [WIDTH-1:0] rdata,
  output logic             full,
  output logic             empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    count;
  logic             do_push, do_pop;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign do_push = push && !full;
  assign do_pop  = pop && !empty;

  // Storage has no reset so it maps onto RAM.
  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= step(wr_ptr);
      if (do_pop)  rd_ptr <= step(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign rdata = mem[rd_ptr];
  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);

  // R8: occupancy never exceeds the depth
  a_r8_count_in_range: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));
  // R8: a push into a full queue leaves the write side untouched
  a_r8_full_refuses: assert property (@(posedge clk) disable iff (rst)
    (full && push && !pop) |=> (full && $stable(wr_ptr)));
endmodule

// File: rtl/spi_qcs_engine.sv
`timescale 1ns/1ps
module spi_qcs_engine
  import spi_qcs_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DIV_W-1:0]  half_div,
  input  logic [WORD_W-1:0] tx_word,
  input  logic              tx_avail,
  output logic              tx_take,
  output logic [WORD_W-1:0] rx_word,
  output logic              rx_push,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic              cs_n,
  output logic              busy
);
  localparam int BW = (WORD_W > 2) ? $clog2(WORD_W) : 1;
  localparam logic [BW-1:0] LAST_BIT = BW'(WORD_W - 1);

  eng_state_t          state;
  logic [DIV_W-1:0]    div_cnt, hd;
  logic [BW-1:0]       bit_cnt;
  logic [WORD_W-2:0]   tx_rest;
  logic [WORD_W-2:0]   rx_sh;
  logic                tick, rise_now, fall_now, word_end;

  assign hd       = (half_div == '0) ? DIV_W'(1) : half_div;
  assign tick     = (state != ENG_IDLE) && (div_cnt == hd - 1'b1);
  assign rise_now = (state == ENG_SHIFT) && tick && !sclk;
  assign fall_now = (state == ENG_SHIFT) && tick && sclk;
  assign word_end = fall_now && (bit_cnt == LAST_BIT);

  assign tx_take = tx_avail && (((state == ENG_IDLE)) || word_end);
  assign rx_word = {rx_sh, miso};
  assign rx_push = rise_now && (bit_cnt == LAST_BIT);

  always_ff @(posedge clk) begin
    if (rst || state == ENG_IDLE || tick) div_cnt <= '0;
    else                                  div_cnt <= div_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ENG_IDLE;
      sclk    <= 1'b0;
      mosi    <= 1'b0;
      cs_n    <= 1'b1;
      busy    <= 1'b0;
      bit_cnt <= '0;
      tx_rest <= '0;
      rx_sh   <= '0;
    end else begin
      case (state)
        ENG_IDLE: begin
          if (tx_avail) begin
            mosi    <= tx_word[WORD_W-1];
            tx_rest <= tx_word[WORD_W-2:0];
            bit_cnt <= '0;
            cs_n    <= 1'b0;
            busy    <= 1'b1;
            state   <= ENG_SHIFT;
          end
        end
        ENG_SHIFT: begin
          if (rise_now) begin
            sclk  <= 1'b1;
            rx_sh <= rx_word[WORD_W-2:0];
          end else if (fall_now) begin
            sclk <= 1'b0;
            if (bit_cnt == LAST_BIT) begin
              bit_cnt <= '0;
              if (tx_avail) begin
                mosi    <= tx_word[WORD_W-1];
                tx_rest <= tx_word[WORD_W-2:0];
              end else begin
                state <= ENG_HOLD;
              end
            end else begin
              bit_cnt <= bit_cnt + 1'b1;
              mosi    <= tx_rest[WORD_W-2];
              tx_rest <= tx_rest << 1;
            end
          end
        end
        ENG_HOLD: begin
          if (tick) begin
            cs_n  <= 1'b1;
            busy  <= 1'b0;
            state <= ENG_IDLE;
          end
        end
        default: state <= ENG_IDLE;
      endcase
    end
  end

  // R3: data is steady whenever the serial clock rises
  a_r3_mosi_steady_at_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(sclk) |-> $stable(mosi));
  // R11: no clock activity outside a select window
  a_r11_clock_only_selected: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> !sclk);
  // R5: select cannot rise while a word is being shifted
  a_r5_select_held_in_word: assert property (@(posedge clk) disable iff (rst)
    (state == ENG_SHIFT) |=> !cs_n);
  // R10: busy mirrors the select window
  a_r10_busy_tracks_select: assert property (@(posedge clk) disable iff (rst)
    busy == !cs_n);
endmodule

// File: rtl/spi_qcs_master.sv
`timescale 1ns/1ps
module spi_qcs_master #(
  parameter int WORD_W     = 16,
  parameter int FIFO_DEPTH = 4,
  parameter int DIV_W      = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DIV_W-1:0]  half_div,
  input  logic [WORD_W-1:0] tx_data,
  input  logic              tx_push,
  output logic              tx_not_full,
  output logic              tx_empty,
  output logic [WORD_W-1:0] rx_data,
  input  logic              rx_pop,
  output logic              rx_valid,
  output logic              rx_overflow,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic              cs_n,
  output logic              busy
);
  logic [WORD_W-1:0] txq_head, eng_rx_word;
  logic              txq_full, txq_empty, eng_take;
  logic              eng_rx_push, rxq_full, rxq_empty;

  spi_qcs_fifo #(.WIDTH(WORD_W), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rst(rst),
    .push(tx_push), .wdata(tx_data),
    .pop(eng_take), .rdata(txq_head),
    .full(txq_full), .empty(txq_empty)
  );

  spi_qcs_engine #(.WORD_W(WORD_W), .DIV_W(DIV_W)) u_eng (
    .clk(clk), .rst(rst), .half_div(half_div),
    .tx_word(txq_head), .tx_avail(!txq_empty), .tx_take(eng_take),
    .rx_word(eng_rx_word), .rx_push(eng_rx_push),
    .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n), .busy(busy)
  );

  spi_qcs_fifo #(.WIDTH(WORD_W), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rst(rst),
    .push(eng_rx_push), .wdata(eng_rx_word),
    .pop(rx_pop), .rdata(rx_data),
    .full(rxq_full), .empty(rxq_empty)
  );

  // Sticky drop flag: setting wins over a same-cycle pop.
  always_ff @(posedge clk) begin
    if (rst)                          rx_overflow <= 1'b0;
    else if (eng_rx_push && rxq_full) rx_overflow <= 1'b1;
    else if (rx_pop)                  rx_overflow <= 1'b0;
  end

  assign tx_not_full = !txq_full;
  assign tx_empty    = txq_empty;
  assign rx_valid    = !rxq_empty;

  // R9: a word arriving at a full receive queue raises the flag
  a_r9_drop_sets_flag: assert property (@(posedge clk) disable iff (rst)
    (eng_rx_push && rxq_full) |=> rx_overflow);
  // R9: the flag holds until the host pops
  a_r9_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    (rx_overflow && !rx_pop) |=> rx_overflow);
endmodule

// File: tb/spi_qcs_master_tb.sv
`timescale 1ns/1ps
module spi_qcs_slave_model #(
  parameter int W = 16
) (
  input  logic         cs_n,
  input  logic         sclk,
  input  logic         mosi,
  input  int           now_cyc,
  input  logic [W-1:0] reply_base,
  output logic         miso
);
  logic [W-1:0] rx_sh, tx_sh;
  logic [W-1:0] got [0:15];
  logic cs_q = 1'b1, sc_q = 1'b0;
  int bitc, wordk, nwords, edges, windows;
  int t_cs, t_edge, setup_c, hold_c, min_h, max_h;
  bit first, load_pend;

  task automatic clear();
    nwords = 0; edges = 0; windows = 0;
    min_h = 1000000; max_h = 0; setup_c = 0; hold_c = 0;
  endtask

  task automatic note_half();
    int d;
    d = now_cyc - t_edge;
    if (d < min_h) min_h = d;
    if (d > max_h) max_h = d;
  endtask

  initial begin
    miso = 1'b0; rx_sh = '0; tx_sh = '0; bitc = 0; wordk = 0;
    t_cs = 0; t_edge = 0; first = 0; load_pend = 0;
    clear();
  end

  always @(cs_n or sclk) begin
    if (cs_q === 1'b1 && cs_n === 1'b0) begin
      windows++; bitc = 0; wordk = 0; tx_sh = reply_base;
      miso = reply_base[W-1]; t_cs = now_cyc; first = 1; load_pend = 0;
    end else if (cs_q === 1'b0 && cs_n === 1'b1) begin
      hold_c = now_cyc - t_edge;
    end else if (cs_n === 1'b0 && sc_q === 1'b0 && sclk === 1'b1) begin
      if (first) begin setup_c = now_cyc - t_cs; first = 0; end
      else note_half();
      t_edge = now_cyc; edges++;
      rx_sh = {rx_sh[W-2:0], mosi}; bitc++;
      if (bitc == W) begin
        if (nwords < 16) got[nwords] = rx_sh;
        nwords++; bitc = 0; wordk++;
        tx_sh = reply_base + W'(wordk); load_pend = 1;
      end
    end else if (cs_n === 1'b0 && sc_q === 1'b1 && sclk === 1'b0) begin
      note_half(); t_edge = now_cyc;
      if (load_pend) load_pend = 0;
      else tx_sh = tx_sh << 1;
      miso = tx_sh[W-1];
    end
    cs_q = cs_n; sc_q = sclk;
  end
endmodule

module spi_qcs_master_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  int   cyc = 0;
  int   checks = 0, errors = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // 16-bit instance
  logic [7:0]  half_div = 8'd2;
  logic [15:0] tx_data = '0, rx_data, reply16 = '0;
  logic tx_push = 0, rx_pop = 0, tx_not_full, tx_empty, rx_valid, rx_overflow;
  logic sclk, mosi, miso, cs_n, busy;

  spi_qcs_master #(.WORD_W(16), .FIFO_DEPTH(4), .DIV_W(8)) u_dut (
    .clk(clk), .rst(rst), .half_div(half_div),
    .tx_data(tx_data), .tx_push(tx_push), .tx_not_full(tx_not_full), .tx_empty(tx_empty),
    .rx_data(rx_data), .rx_pop(rx_pop), .rx_valid(rx_valid), .rx_overflow(rx_overflow),
    .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n), .busy(busy));

  spi_qcs_slave_model #(.W(16)) m16 (
    .cs_n(cs_n), .sclk(sclk), .mosi(mosi), .now_cyc(cyc),
    .reply_base(reply16), .miso(miso));

  // 8-bit instance
  logic [7:0] half_div8 = 8'd2, tx_data8 = '0, rx_data8, reply8 = '0;
  logic tx_push8 = 0, rx_pop8 = 0, tx_not_full8, tx_empty8, rx_valid8, rx_overflow8;
  logic sclk8, mosi8, miso8, cs_n8, busy8;

  spi_qcs_master #(.WORD_W(8), .FIFO_DEPTH(4), .DIV_W(8)) u_dut8 (
    .clk(clk), .rst(rst), .half_div(half_div8),
    .tx_data(tx_data8), .tx_push(tx_push8), .tx_not_full(tx_not_full8), .tx_empty(tx_empty8),
    .rx_data(rx_data8), .rx_pop(rx_pop8), .rx_valid(rx_valid8), .rx_overflow(rx_overflow8),
    .sclk(sclk8), .mosi(mosi8), .miso(miso8), .cs_n(cs_n8), .busy(busy8));

  spi_qcs_slave_model #(.W(8)) m8 (
    .cs_n(cs_n8), .sclk(sclk8), .mosi(mosi8), .now_cyc(cyc),
    .reply_base(reply8), .miso(miso8));

  logic [15:0] rxv [0:7];
  int rxn;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push16(input logic [15:0] d);
    @(negedge clk);
    while (!tx_not_full) @(negedge clk);
    tx_data = d; tx_push = 1'b1;
    @(negedge clk);
    tx_push = 1'b0;
  endtask

  task automatic wait_idle16();
    int n = 0;
    while ((busy || !tx_empty) && n < 20000) begin @(negedge clk); n++; end
    repeat (2) @(negedge clk);
  endtask

  task automatic drain16();
    rxn = 0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (!rx_valid) break;
      rxv[rxn] = rx_data; rxn++;
      rx_pop = 1'b1;
      @(negedge clk);
      rx_pop = 1'b0;
    end
  endtask

  task automatic t_reset();
    chk("R1 cs_n", 64'(cs_n), 64'd1);
    chk("R1 sclk", 64'(sclk), 64'd0);
    chk("R1 busy", 64'(busy), 64'd0);
    chk("R1 tx_empty", 64'(tx_empty), 64'd1);
    chk("R1 tx_not_full", 64'(tx_not_full), 64'd1);
    chk("R1 rx_valid", 64'(rx_valid), 64'd0);
    chk("R1 rx_overflow", 64'(rx_overflow), 64'd0);
  endtask

  task automatic t_idle();
    m16.clear();
    repeat (40) @(negedge clk);
    chk("R11 no edges", 64'(m16.edges), 64'd0);
    chk("R11 no window", 64'(m16.windows), 64'd0);
    chk("R11 select high", 64'(cs_n), 64'd1);
  endtask

  task automatic t_single();
    half_div = 8'd2; reply16 = 16'h3C5A; m16.clear();
    push16(16'hA5C3);
    repeat (3) @(negedge clk);
    chk("R10 busy in window", 64'(busy), 64'd1);
    chk("R10 select low", 64'(cs_n), 64'd0);
    wait_idle16();
    chk("R10 busy released", 64'(busy), 64'd0);
    chk("R6 one window", 64'(m16.windows), 64'd1);
    chk("R6 edge count", 64'(m16.edges), 64'd16);
    chk("R2 slave word", 64'(m16.got[0]), 64'hA5C3);
    chk("R4 min half", 64'(m16.min_h), 64'd2);
    chk("R4 max half", 64'(m16.max_h), 64'd2);
    chk("R7 setup", 64'(m16.setup_c), 64'd2);
    chk("R7 hold", 64'(m16.hold_c), 64'd2);
    drain16();
    chk("R2 rx count", 64'(rxn), 64'd1);
    chk("R2 rx word", 64'(rxv[0]), 64'h3C5A);
  endtask

  task automatic t_div3();
    half_div = 8'd3; reply16 = 16'h8000; m16.clear();
    push16(16'h0001);
    wait_idle16();
    chk("R4 div3 min half", 64'(m16.min_h), 64'd3);
    chk("R4 div3 max half", 64'(m16.max_h), 64'd3);
    chk("R7 div3 setup", 64'(m16.setup_c), 64'd3);
    chk("R2 lsb word", 64'(m16.got[0]), 64'h0001);
    drain16();
    chk("R2 msb reply", 64'(rxv[0]), 64'h8000);
  endtask

  task automatic t_b2b();
    half_div = 8'd2; reply16 = 16'h1234; m16.clear();
    push16(16'hF00F);
    push16(16'h0FF0);
    wait_idle16();
    chk("R5 one window", 64'(m16.windows), 64'd1);
    chk("R5 edges", 64'(m16.edges), 64'd32);
    chk("R5 no gap", 64'(m16.max_h), 64'd2);
    chk("R5 word0", 64'(m16.got[0]), 64'hF00F);
    chk("R5 word1", 64'(m16.got[1]), 64'h0FF0);
    drain16();
    chk("R5 rx count", 64'(rxn), 64'd2);
    chk("R5 rx0", 64'(rxv[0]), 64'h1234);
    chk("R5 rx1", 64'(rxv[1]), 64'h1235);
  endtask

  task automatic t_full();
    half_div = 8'd2; reply16 = 16'h0000; m16.clear();
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      tx_data = 16'hC000 + 16'(i); tx_push = 1'b1;
    end
    @(negedge clk);
    tx_push = 1'b0;
    chk("R8 full flag", 64'(tx_not_full), 64'd0);
    chk("R8 not empty", 64'(tx_empty), 64'd0);
    wait_idle16();
    chk("R8 words sent", 64'(m16.nwords), 64'd5);
    chk("R8 last sent", 64'(m16.got[4]), 64'hC004);
    chk("R8 one window", 64'(m16.windows), 64'd1);
    chk("R8 space back", 64'(tx_not_full), 64'd1);
    drain16();
  endtask

  task automatic t_overflow();
    half_div = 8'd1; reply16 = 16'h0100; m16.clear();
    for (int i = 0; i < 5; i++) push16(16'h7700 + 16'(i));
    wait_idle16();
    chk("R9 flag set", 64'(rx_overflow), 64'd1);
    chk("R9 half div1", 64'(m16.max_h), 64'd1);
    @(negedge clk);
    chk("R9 first kept", 64'(rx_data), 64'h0100);
    rx_pop = 1'b1;
    @(negedge clk);
    rx_pop = 1'b0;
    chk("R9 flag cleared", 64'(rx_overflow), 64'd0);
    drain16();
    chk("R9 kept count", 64'(rxn), 64'd3);
    chk("R9 word1", 64'(rxv[0]), 64'h0101);
    chk("R9 word3", 64'(rxv[2]), 64'h0103);
  endtask

  task automatic t_w8();
    int n = 0;
    half_div8 = 8'd2; reply8 = 8'h5B; m8.clear();
    @(negedge clk); tx_data8 = 8'h96; tx_push8 = 1'b1;
    @(negedge clk); tx_push8 = 1'b0;
    @(negedge clk); tx_data8 = 8'h3C; tx_push8 = 1'b1;
    @(negedge clk); tx_push8 = 1'b0;
    while ((busy8 || !tx_empty8) && n < 20000) begin @(negedge clk); n++; end
    repeat (2) @(negedge clk);
    chk("R12 one window", 64'(m8.windows), 64'd1);
    chk("R12 edges", 64'(m8.edges), 64'd16);
    chk("R12 word0", 64'(m8.got[0]), 64'h96);
    chk("R12 word1", 64'(m8.got[1]), 64'h3C);
    chk("R12 rx0", 64'(rx_data8), 64'h5B);
    rx_pop8 = 1'b1; @(negedge clk); rx_pop8 = 1'b0;
    chk("R12 rx1", 64'(rx_data8), 64'h5C);
    rx_pop8 = 1'b1; @(negedge clk); rx_pop8 = 1'b0;
    chk("R12 rx drained", 64'(rx_valid8), 64'd0);
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_idle();
    t_single();
    t_div3();
    t_b2b();
    t_full();
    t_overflow();
    t_w8();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule